// File: doc/BRIEF.md
# Cyclic Squelch Code Serializer

This block holds a digital squelch code word of 23 or 24 bits and serves it in both radio directions. Software, or a neighbouring controller, writes the word one byte at a time through a small register port. While transmit is enabled, the block sends the word on a single serial line. It starts with bit 0, moves on one bit for each bit-rate strobe, and loops back to bit 0 after the last bit of the frame, with no gap.

The same word is used for receive. On every strobe one incoming bit is shifted into a window. A match flag goes high when the most recent 23 or 24 received bits, taken in the order they arrived, equal the word in the order it would be sent. A write, or a change of frame length, made while a frame is going out is held back until that frame ends. A frame therefore never mixes an old code with a new one.

The transmit side is a three-state machine. ST_IDLE drives the line low, holds the bit pointer at 0 and copies the written code into the working copy on every cycle. ST_SEND walks through the frame. ST_FINAL covers the last bit of the frame. The transitions are:
- ST_IDLE to ST_SEND when enable is high.
- ST_SEND to ST_FINAL on the strobe that moves the pointer onto the last bit.
- ST_FINAL to ST_SEND on the next strobe. On that strobe the pointer wraps to 0 and the working copy reloads.
- ST_SEND or ST_FINAL back to ST_IDLE as soon as enable is low.

Top module: `dcs_serializer`

## Requirements
- R1: Byte address 0 writes code bits 23:16, address 1 writes bits 15:8 and address 2 writes bits 7:0. A write to address 3 changes nothing that is sent or matched.
- R2: One clock cycle after enable goes high, tx_bit shows code bit 0. Each bit_stb moves tx_bit to the next higher bit, so the code goes out least significant bit first.
- R3: With len24 = 1 the frame has 24 bits, and bit 23 is the last bit sent before the wrap.
- R4: With len24 = 0 the frame has 23 bits, and bit 22 is the last bit sent. Bit 23 is never sent.
- R5: On the strobe after the last bit of a frame, the output returns to bit 0. The code repeats for as long as enable stays high.
- R6: A byte write or a change of len24 made during a frame takes effect at the start of the next frame. The rest of the current frame keeps the old code and the old length.
- R7: One cycle after enable goes low, tx_bit is low and the bit pointer is back at 0. Enabling again restarts the frame at bit 0.
- R8: One cycle after a bit_stb, rx_match is 1 exactly when at least L bits have arrived since reset and the last L received bits equal code bits 0..L-1, with the oldest of those bits compared against bit 0. L is 24 or 23 according to len24. The word compared is the same one used for transmit.
- R9: The first strobe whose window does not equal the code clears rx_match.
- R10: After reset, tx_bit and rx_match are 0 and all code bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 2 | Byte register address |
| wr_data | input | 8 | Byte to write |
| len24 | input | 1 | Frame length: 1 selects 24 bits, 0 selects 23 bits |
| enable | input | 1 | Transmit enable |
| bit_stb | input | 1 | Bit-rate strobe, one cycle wide |
| rx_bit | input | 1 | Serial receive data, sampled on bit_stb |
| tx_bit | output | 1 | Serial transmit data |
| rx_match | output | 1 | Receive window equals the code |

## Verification
The assertions assume that bit_stb is a single-cycle pulse. They also assume that a new word and length are written only while transmit is idle, or else are left to be picked up at a frame boundary. Finally, they assume that the length seen by the checks is the working copy captured at a boundary, not the live len24 pin. The bench drives every input on the falling clock edge, and it holds each strobe high for exactly one cycle. It waits one idle cycle after its last write before enabling transmit, so a write never lands in the same cycle as the start of a frame. The receive window is only checked after a reset, so the expected fill count starts from zero.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SEND  = 2'd1,
        ST_FINAL = 2'd2
    } tx_state_t;
endpackage

// File: rtl/dcs_code_regs.sv
module dcs_code_regs #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 2,
    localparam int WORD_W   = BYTE_W * NUM_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              len24_in,
    input  logic              load,
    output logic [WORD_W-1:0] active_word,
    output logic              active_len24
);
    logic [WORD_W-1:0] pending_word;

    // lowest address holds the most significant byte
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_addr == ADDR_W'(g)))
                q <= wr_data;
        end
        assign pending_word[(NUM_BYTES-1-g)*BYTE_W +: BYTE_W] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active_word  <= '0;
            active_len24 <= 1'b1;
        end else if (load) begin
            active_word  <= pending_word;
            active_len24 <= len24_in;
        end
    end

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(active_word) && $stable(active_len24))); // R6
endmodule

// File: rtl/dcs_tx_fsm.sv
module dcs_tx_fsm
    import dcs_pkg::*;
#(
    parameter int WORD_W = 24,
    localparam int PTR_W = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bit_stb,
    input  logic              len24,
    input  logic [WORD_W-1:0] word,
    output logic              tx_bit,
    output logic              frame_load
);
    tx_state_t        state, state_nxt;
    logic [PTR_W-1:0] ptr;
    logic [PTR_W-1:0] last_idx;

    assign last_idx = len24 ? PTR_W'(WORD_W-1) : PTR_W'(WORD_W-2);

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (enable) state_nxt = ST_SEND;
            ST_SEND:  if (!enable) state_nxt = ST_IDLE;
                      else if (bit_stb && (ptr == last_idx - PTR_W'(1)))
                          state_nxt = ST_FINAL;
            ST_FINAL: if (!enable) state_nxt = ST_IDLE;
                      else if (bit_stb) state_nxt = ST_SEND;
            default:  state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (state_nxt == ST_IDLE)
            ptr <= '0;
        else if (bit_stb && (state != ST_IDLE))
            ptr <= (state == ST_FINAL) ? '0 : ptr + PTR_W'(1);
    end

    always_comb begin
        tx_bit     = 1'b0;
        frame_load = 1'b0;
        unique case (state)
            ST_IDLE:  frame_load = 1'b1;
            ST_SEND:  tx_bit = word[ptr];
            ST_FINAL: begin
                tx_bit     = word[ptr];
                frame_load = bit_stb && enable;
            end
            default:  frame_load = 1'b1;
        endcase
    end

    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ptr <= last_idx); // R4
    AST_FINAL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINAL) |-> (ptr == last_idx)); // R3
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SEND && bit_stb && enable) |=> (ptr == $past(ptr) + PTR_W'(1))); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINAL && bit_stb && enable) |=> (ptr == '0 && state == ST_SEND)); // R5
    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!tx_bit && ptr == '0)); // R7
endmodule

// File: rtl/dcs_rx_match.sv
module dcs_rx_match #(
    parameter int WORD_W = 24,
    localparam int CNT_W = $clog2(WORD_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_stb,
    input  logic              rx_bit,
    input  logic              len24,
    input  logic [WORD_W-1:0] word,
    output logic              rx_match
);
    logic [WORD_W-1:0] window, window_nxt;
    logic [CNT_W-1:0]  fill, fill_nxt, need;
    logic              hit;

    // newest bit enters at the top, oldest sits at the bottom
    assign window_nxt = {rx_bit, window[WORD_W-1:1]};
    assign fill_nxt   = (fill == CNT_W'(WORD_W)) ? fill : fill + CNT_W'(1);
    assign need       = len24 ? CNT_W'(WORD_W) : CNT_W'(WORD_W-1);
    assign hit        = len24 ? (window_nxt == word)
                              : (window_nxt[WORD_W-1:1] == word[WORD_W-2:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            window   <= '0;
            fill     <= '0;
            rx_match <= 1'b0;
        end else if (bit_stb) begin
            window   <= window_nxt;
            fill     <= fill_nxt;
            rx_match <= hit && (fill_nxt >= need);
        end
    end

    AST_MATCH_FILLED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_match |-> (fill >= CNT_W'(WORD_W-1))); // R8
    AST_FILL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNT_W'(WORD_W)); // R8
endmodule

// File: rtl/dcs_serializer.sv
module dcs_serializer #(
    parameter int BYTE_W    = 8,
    parameter int NUM_BYTES = 3,
    parameter int ADDR_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              len24,
    input  logic              enable,
    input  logic              bit_stb,
    input  logic              rx_bit,
    output logic              tx_bit,
    output logic              rx_match
);
    localparam int WORD_W = BYTE_W * NUM_BYTES;

    logic [WORD_W-1:0] active_word;
    logic              active_len24;
    logic              frame_load;

    dcs_code_regs #(.BYTE_W(BYTE_W), .NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .len24_in     (len24),
        .load         (frame_load),
        .active_word  (active_word),
        .active_len24 (active_len24)
    );

    dcs_tx_fsm #(.WORD_W(WORD_W)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .bit_stb    (bit_stb),
        .len24      (active_len24),
        .word       (active_word),
        .tx_bit     (tx_bit),
        .frame_load (frame_load)
    );

    dcs_rx_match #(.WORD_W(WORD_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_stb  (bit_stb),
        .rx_bit   (rx_bit),
        .len24    (active_len24),
        .word     (active_word),
        .rx_match (rx_match)
    );

    AST_RESET_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (!tx_bit && !rx_match)); // R10
endmodule

// File: tb/sim_dcs_serializer.sv
module sim_dcs_serializer;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       len24 = 1'b1;
    logic       enable = 1'b0;
    logic       bit_stb = 1'b0;
    logic       rx_bit = 1'b0;
    logic       tx_bit, rx_match;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic recv [0:255];
    int  n_recv = 0;

    always #(PERIOD/2) clk = ~clk;

    dcs_serializer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .len24(len24), .enable(enable),
        .bit_stb(bit_stb), .rx_bit(rx_bit), .tx_bit(tx_bit), .rx_match(rx_match)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        n_recv = 0;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_word(input logic [23:0] w);
        wr(2'd0, w[23:16]);
        wr(2'd1, w[15:8]);
        wr(2'd2, w[7:0]);
        @(negedge clk);
    endtask

    task automatic strobe(input logic b);
        bit_stb = 1'b1; rx_bit = b;
        @(negedge clk);
        bit_stb = 1'b0;
        recv[n_recv] = b;
        n_recv++;
    endtask

    function automatic logic exp_match(input int l, input logic [23:0] w);
        if (n_recv < l) return 1'b0;
        for (int j = 0; j < l; j++)
            if (recv[n_recv - l + j] != w[j]) return 1'b0;
        return 1'b1;
    endfunction

    // walk bits [from, to) of a frame of word w, checking each then strobing
    task automatic walk(input string req, input logic [23:0] w, input int from, input int to);
        for (int i = from; i < to; i++) begin
            check(req, tx_bit, w[i]);
            strobe(1'b0);
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [23:0] w, w2;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 tx", tx_bit, 1'b0);
        check("R10 match", rx_match, 1'b0);
        enable = 1'b1; @(negedge clk);
        walk("R10 zero code", 24'h0, 0, 24);
        enable = 1'b0; @(negedge clk);

        // sweep codes in both lengths, two frames each (R1 R2 R3 R4 R5)
        for (int k = 0; k < 6; k++) begin
            w = (24'(k) * 24'h5A3C71 + 24'h13579B) ^ (24'(k) << 7);
            for (int m = 0; m < 2; m++) begin
                len24 = (m == 0);
                load_word(w);
                enable = 1'b1; @(negedge clk);
                if (m == 0) begin
                    walk("R2 R3 frame24", w, 0, 24);
                    walk("R5 repeat24", w, 0, 24);
                    check("R5 wrap24", tx_bit, w[0]);
                end else begin
                    walk("R1 R4 frame23", w, 0, 23);
                    walk("R5 repeat23", w, 0, 23);
                    check("R4 wrap23 skips bit23", tx_bit, w[0]);
                end
                enable = 1'b0; @(negedge clk);
                check("R7 off low", tx_bit, 1'b0);
            end
        end

        // R1 address 3 has no effect
        len24 = 1'b1;
        w = 24'hC3A51E;
        load_word(w);
        wr(2'd3, 8'hFF); @(negedge clk);
        enable = 1'b1; @(negedge clk);
        walk("R1 addr3 ignored", w, 0, 24);
        enable = 1'b0; @(negedge clk);

        // R6 write and length change mid-frame
        w = 24'h9E4D27;
        w2 = {w[23:8], 8'h6B};
        len24 = 1'b1;
        load_word(w);
        enable = 1'b1; @(negedge clk);
        walk("R6 before write", w, 0, 10);
        wr(2'd2, 8'h6B);
        len24 = 1'b0;
        @(negedge clk);
        walk("R6 old frame kept", w, 10, 24);
        walk("R6 new frame23", w2, 0, 23);
        check("R6 new length wraps", tx_bit, w2[0]);

        // R7 disable mid-frame, re-enable restarts at bit 0
        walk("R7 run", w2, 0, 5);
        enable = 1'b0; @(negedge clk);
        check("R7 low when off", tx_bit, 1'b0);
        strobe(1'b0);
        check("R7 low with strobe", tx_bit, 1'b0);
        enable = 1'b1; @(negedge clk);
        walk("R7 restart bit0", w2, 0, 3);
        enable = 1'b0; @(negedge clk);

        // R8 R9 receive window, both lengths
        for (int m = 0; m < 2; m++) begin
            do_reset();
            w = (m == 0) ? 24'h5B1E93 : 24'hA72C4D;
            len24 = (m == 0);
            load_word(w);
            for (int i = 0; i < 7; i++) begin
                strobe(logic'((i * 5 + 3) % 3 == 0));
                check("R8 noise", rx_match, exp_match(m == 0 ? 24 : 23, w));
            end
            for (int r = 0; r < 2; r++)
                for (int i = 0; i < (m == 0 ? 24 : 23); i++) begin
                    strobe(w[i]);
                    check("R8 window", rx_match, exp_match(m == 0 ? 24 : 23, w));
                end
            strobe(~w[m == 0 ? 24 - 23 : 23 - 23]);
            check("R9 mismatch clears", rx_match, exp_match(m == 0 ? 24 : 23, w));
            check("R9 cleared", rx_match, 1'b0);
            for (int i = 0; i < 30; i++) begin
                strobe(w[(i + 2) % (m == 0 ? 24 : 23)]);
                check("R8 R9 resync", rx_match, exp_match(m == 0 ? 24 : 23, w));
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule